// File: doc/BRIEF.md
# Supervisory Delay Timer with Gated Start Inputs

This block is a millisecond timer for relay-style protection logic. It holds one of three exclusive states (stopped, running, expired) and shows the state on three one-hot status outputs. The timeout is counted in 1 ms ticks, supplied as a one-cycle strobe, against a 16-bit delay. The delay comes either from a runtime input or from a constant fixed when the block is instantiated.

Six control inputs move the timer between states. A stop input acts on its rising edge. An unconditional start input holds the timer in running with the count at zero for as long as it stays high. A pick-up input starts the timer on its rising edge and drops the timer back to stopped on its falling edge. Three conditional starts each act only from particular states. When several inputs are active in the same cycle, a fixed priority settles the result.

The usual pick-up delay use drives the pick-up input from a protection-started signal and takes the expired output as the trip command. The unconditional start with the running output gives a drop-off delay, or pulse stretcher.

Top module: `sup_delay_timer`

## Requirements
- R1: After reset the timer is stopped. At every cycle exactly one of running_o, expired_o and stopped_o is high.
- R2: In any cycle where start_i is high and no stop edge is present, the timer enters running with its count at zero, whatever its prior state. Counting resumes only after start_i falls, so every new start pulse retriggers the timeout.
- R3: A rising edge on stop_i puts the timer in stopped on the next clock. A timer stopped while running never shows expired. A stop_i level held high does not block later starts.
- R4: start_nr_i starts the timer from stopped or expired. While the timer is running, start_nr_i is ignored and does not extend the run.
- R5: start_exp_i starts the timer only from expired and has no effect in stopped or running. If it is held high, the timer restarts after each timeout, and expired lasts one cycle.
- R6: start_stp_i starts the timer only from stopped and has no effect in running or expired.
- R7: A rising edge on delay_i starts the timer from stopped or expired, and has no effect while running. The timer stays expired while delay_i remains high. A falling edge of delay_i puts the timer in stopped from any state.
- R8: A delay_i pulse that ends before the timeout never makes expired_o high.
- R9: With USE_PARAM = 1 the delay is taken from delay_param_i. With USE_PARAM = 0 the delay is CONST_DELAY, and delay_param_i has no effect.
- R10: Only cycles with tick_1ms high advance the count. The timer expires on the tick that brings the count to the delay value: D ticks after counting begins for D of 1 or more, and on the first tick for D = 0.
- R11: Inputs active in the same cycle are resolved in this priority: stop edge, then start_i, then the delay_i falling edge, then the delay_i rising edge, then start_nr_i, start_exp_i and start_stp_i in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle 1 ms timebase strobe |
| stop_i | input | 1 | Stop, acts on its rising edge |
| start_i | input | 1 | Unconditional start, level sensitive |
| start_nr_i | input | 1 | Start when not running |
| start_exp_i | input | 1 | Start when expired |
| start_stp_i | input | 1 | Start when stopped |
| delay_i | input | 1 | Pick-up input, edge sensitive |
| delay_param_i | input | DLY_W | Runtime delay in ticks |
| running_o | output | 1 | Timer is counting |
| expired_o | output | 1 | Timeout reached |
| stopped_o | output | 1 | Neither running nor expired |

## Verification
The bench builds two instances side by side from the same stimulus. The first takes its delay from the runtime input, which the bench drives to small values from 0 to 6, including zero. The second uses USE_PARAM = 0 with CONST_DELAY = 5 while the runtime input keeps changing. With such short delays, timeouts, the repeated restarts of a held start-if-expired input and the removal of a delay pulse after expiry all happen within a few cycles. Random stimulus can therefore reach every state-and-input combination many times, including inputs that arrive together and fall under the priority rule.

// File: rtl/sup_delay_timer.sv
module sup_delay_timer #(
  parameter int               DLY_W       = 16,
  parameter bit               USE_PARAM   = 1'b1,
  parameter logic [DLY_W-1:0] CONST_DELAY = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             stop_i,
  input  logic             start_i,
  input  logic             start_nr_i,
  input  logic             start_exp_i,
  input  logic             start_stp_i,
  input  logic             delay_i,
  input  logic [DLY_W-1:0] delay_param_i,
  output logic             running_o,
  output logic             expired_o,
  output logic             stopped_o
);

  typedef enum logic [1:0] {ST_STOP = 2'd0, ST_RUN = 2'd1, ST_EXP = 2'd2} st_t;

  st_t              st, st_nxt;
  logic [DLY_W-1:0] cnt, cnt_nxt;
  logic             stop_q, dly_q;

  wire             stop_rise = stop_i & ~stop_q;
  wire             dly_rise  = delay_i & ~dly_q;
  wire             dly_fall  = ~delay_i & dly_q;
  wire [DLY_W-1:0] dly_eff   = USE_PARAM ? delay_param_i : CONST_DELAY;
  wire [DLY_W:0]   cnt_inc   = {1'b0, cnt} + 1'b1;
  wire             reach     = cnt_inc >= {1'b0, dly_eff};

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (stop_rise) begin
      st_nxt = ST_STOP; cnt_nxt = '0;
    end else if (start_i) begin
      st_nxt = ST_RUN;  cnt_nxt = '0;
    end else if (dly_fall) begin
      st_nxt = ST_STOP; cnt_nxt = '0;
    end else if ((dly_rise || start_nr_i) && st != ST_RUN) begin
      st_nxt = ST_RUN;  cnt_nxt = '0;
    end else if (start_exp_i && st == ST_EXP) begin
      st_nxt = ST_RUN;  cnt_nxt = '0;
    end else if (start_stp_i && st == ST_STOP) begin
      st_nxt = ST_RUN;  cnt_nxt = '0;
    end else if (st == ST_RUN && tick_1ms) begin
      if (reach) st_nxt = ST_EXP;
      else       cnt_nxt = cnt_inc[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_STOP;
      cnt    <= '0;
      stop_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      st     <= st_nxt;
      cnt    <= cnt_nxt;
      stop_q <= stop_i;
      dly_q  <= delay_i;
    end
  end

  assign running_o = (st == ST_RUN);
  assign expired_o = (st == ST_EXP);
  assign stopped_o = (st == ST_STOP);

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_rise) |=> (running_o && cnt == '0));

  // R3
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rise |=> stopped_o);

  // R3
  expire_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> $past(running_o));

  // R4
  nr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && start_nr_i && !stop_rise && !start_i && !dly_fall && !tick_1ms)
      |=> (running_o && $stable(cnt)));

  // R5
  exp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && start_exp_i && !start_i && !start_nr_i && !start_stp_i && !dly_rise)
      |=> stopped_o);

  // R7
  dly_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_fall && !stop_rise && !start_i) |=> stopped_o);

endmodule

// File: tb/sup_delay_timer_tb.sv
module sup_delay_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, stop = 1'b0, start = 1'b0, snr = 1'b0, sexp = 1'b0, sstp = 1'b0, dly = 1'b0;
  logic [15:0] dparam = 16'd4;
  logic [2:0] o0, o1;
  int checks = 0, errors = 0, cycles = 0;
  int m_st[2], m_cnt[2];
  logic pstop = 1'b0, pdly = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sup_delay_timer #(.DLY_W(16), .USE_PARAM(1'b1), .CONST_DELAY(16'd150)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .stop_i(stop), .start_i(start),
    .start_nr_i(snr), .start_exp_i(sexp), .start_stp_i(sstp), .delay_i(dly),
    .delay_param_i(dparam), .running_o(o0[2]), .expired_o(o0[1]), .stopped_o(o0[0]));

  sup_delay_timer #(.DLY_W(16), .USE_PARAM(1'b0), .CONST_DELAY(16'd5)) u_dut_const (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .stop_i(stop), .start_i(start),
    .start_nr_i(snr), .start_exp_i(sexp), .start_stp_i(sstp), .delay_i(dly),
    .delay_param_i(dparam), .running_o(o1[2]), .expired_o(o1[1]), .stopped_o(o1[0]));

  function automatic logic [2:0] enc(int s);
    return (s == 1) ? 3'b100 : (s == 2) ? 3'b010 : 3'b001;
  endfunction

  task automatic model_step();
    logic sr, dr, df;
    sr = stop & ~pstop; dr = dly & ~pdly; df = ~dly & pdly;
    for (int i = 0; i < 2; i++) begin
      int d;
      d = (i == 0) ? int'(dparam) : 5;
      if (sr) begin m_st[i] = 0; m_cnt[i] = 0; end
      else if (start) begin m_st[i] = 1; m_cnt[i] = 0; end
      else if (df) begin m_st[i] = 0; m_cnt[i] = 0; end
      else if ((dr || snr) && m_st[i] != 1) begin m_st[i] = 1; m_cnt[i] = 0; end
      else if (sexp && m_st[i] == 2) begin m_st[i] = 1; m_cnt[i] = 0; end
      else if (sstp && m_st[i] == 0) begin m_st[i] = 1; m_cnt[i] = 0; end
      else if (m_st[i] == 1 && tick) begin
        if (m_cnt[i] + 1 >= d) m_st[i] = 2;
        else m_cnt[i] = m_cnt[i] + 1;
      end
    end
    pstop = stop; pdly = dly;
  endtask

  task automatic cmp(string tag);
    checks++;
    if (o0 !== enc(m_st[0]) || o1 !== enc(m_st[1])) begin
      errors++;
      $display("FAIL %s param-inst got %b exp %b, const-inst got %b exp %b",
               tag, o0, enc(m_st[0]), o1, enc(m_st[1]));
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic expect_out(logic [2:0] exp0, string tag);
    checks++;
    if (o0 !== exp0) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, o0, exp0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp("R1 reset");
    expect_out(3'b001, "R1 reset stopped");

    // R2: start held, release, count 4 ticks
    tick = 1'b1; start = 1'b1;
    run(3, "R2 hold");
    start = 1'b0;
    run(3, "R2 counting");
    expect_out(3'b100, "R2 still running");
    step("R2 timeout");
    expect_out(3'b010, "R2 expired after 4 ticks");
    start = 1'b1; step("R2 from expired"); start = 1'b0;
    run(2, "R2 count"); start = 1'b1; step("R2 retrigger"); start = 1'b0;
    run(5, "R2 retrigger timeout");

    // R3: stop edge while running, never expires
    snr = 1'b1; step("R4 start from expired"); snr = 1'b0;
    run(1, "R3 pre");
    stop = 1'b1; step("R3 stop edge");
    expect_out(3'b001, "R3 stopped");
    run(6, "R3 no expire after stop");
    sstp = 1'b1; step("R6 start from stopped (stop level high)"); sstp = 1'b0;
    stop = 1'b0; run(6, "R6 run to expiry");

    // R4: start_nr in running does not extend
    snr = 1'b1; step("R4 start");
    run(4, "R4 ignored while running");
    expect_out(3'b010, "R4 no extension");
    snr = 1'b0; step("R4 idle");

    // R6 no effect in expired, R5 no effect in stopped / held restarts
    sstp = 1'b1; run(2, "R6 no effect in expired"); sstp = 1'b0;
    sexp = 1'b1; run(14, "R5 held restarts");
    sexp = 1'b0; stop = 1'b1; step("R3 stop from expired"); stop = 1'b0;
    sexp = 1'b1; run(3, "R5 no effect in stopped"); sexp = 1'b0;
    expect_out(3'b001, "R5 stays stopped");

    // R7 / R8 delay input
    dly = 1'b1; run(2, "R8 short pulse"); dly = 1'b0; step("R8 drop");
    expect_out(3'b001, "R8 short pulse stopped");
    dly = 1'b1; run(8, "R7 pick-up expired");
    expect_out(3'b010, "R7 held expired");
    dly = 1'b0; step("R7 fall to stopped");
    expect_out(3'b001, "R7 stopped on fall");

    // R10 sparse ticks and zero delay
    tick = 1'b0; snr = 1'b1; step("R10 start"); snr = 1'b0;
    run(5, "R10 no tick no advance");
    expect_out(3'b100, "R10 frozen without tick");
    dparam = 16'd0; tick = 1'b1; step("R10 zero delay");
    expect_out(3'b010, "R10 zero expires first tick");
    dparam = 16'd4;

    // R11 priority
    stop = 1'b1; start = 1'b1; dly = 1'b1; step("R11 stop wins");
    stop = 1'b0; step("R11 start held");
    dly = 1'b0; step("R11 start over delay fall");
    start = 1'b0; dly = 1'b1; step("R11 rise");
    dly = 1'b0; snr = 1'b1; step("R11 fall over start_nr");
    snr = 1'b0;

    // R9 and random mix
    for (int k = 0; k < 4000; k++) begin
      tick  = ($urandom % 2) == 0;
      stop  = ($urandom % 16) == 0;
      start = ($urandom % 12) == 0;
      snr   = ($urandom % 10) == 0;
      sexp  = ($urandom % 6) == 0;
      sstp  = ($urandom % 8) == 0;
      if (($urandom % 7) == 0) dly = ~dly;
      if (($urandom % 20) == 0) dparam = 16'($urandom % 7);
      step("R9 R11 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule